// File: doc/BRIEF.md
# Synthesizer Feedback Divider with Load Latch

This block sits in the feedback path of a frequency synthesizer. A 9-bit divide value arrives on a parallel bus. An active-low load control acts as a transparent latch on that bus. While the control is low, the divider follows the bus directly. When the control rises, the value is frozen, and later bus activity has no effect until the control drops again. The block counts the fast input clock down by the held value and emits a one-cycle pulse each time the count wraps. A phase comparator uses this pulse.

Three further functions sit beside the counter. A flag reports a held value that lies outside the range in which the loop can lock. A toggle stage divides the input clock by two and gives a 50% duty-cycle output. A separate prescaler divides the crystal clock by sixteen to form the reference side of the comparison. A new divide value that arrives partway through a count takes effect only at the next reload, so the period in progress is neither shortened nor stretched.

Top module: `fbdiv_top`

## Requirements
- R1: While `rst` is high, `fb_pulse`, `out_div2` and `ref_div` are all 0.
- R2: While `load_n` is low and `rst` is low, the divider uses the live value of `m_in`. A change reaches `range_err` one `clk` edge later and sets the next full pulse period.
- R3: The value on `m_in` at the last `clk` edge with `load_n` low is held once `load_n` goes high.
- R4: While `load_n` stays high, changes on `m_in` have no effect on `range_err` or on the pulse period.
- R5: For a held value M of 2 or more, `fb_pulse` is high for exactly one `clk` cycle and repeats every M cycles.
- R6: A value that changes in the middle of a count does not alter the period in progress. It governs the period after the next pulse.
- R7: A held value of 0 or 1 keeps `fb_pulse` high on every cycle.
- R8: `range_err` is 1 exactly when the held value is below 190 or above 510. It is updated one `clk` edge after the value changes.
- R9: `out_div2` changes level on every rising `clk` edge once reset is released, giving clk/2 with 50% duty.
- R10: `ref_div` runs at `xtal_clk`/16. It is high for 8 `xtal_clk` cycles and low for 8.
- R11: Reset loads the held value from `m_in` regardless of `load_n`. The first pulse after reset arrives M cycles after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock counted by the feedback divider |
| xtal_clk | input | 1 | Crystal clock feeding the reference prescaler |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| load_n | input | 1 | Load control: low = transparent, rising edge = capture |
| m_in | input | 9 | Parallel divide value |
| fb_pulse | output | 1 | One-cycle pulse at each wrap of the divide counter |
| range_err | output | 1 | Held divide value lies outside 190..510 |
| out_div2 | output | 1 | Input clock divided by two, 50% duty |
| ref_div | output | 1 | Crystal clock divided by sixteen, 50% duty |

## Verification
The bench changes the divide value partway through a count. A design that reloaded at once would produce a short or long pulse gap there, and the bench would see it.

It drives junk on the bus after capture, including a value that would raise the range flag. A leaky latch would show up as a changed flag or period.

It tests the range edges at 189, 190, 510 and 511, where an off-by-one comparison would misreport. It also tests divide values of 0 and 1, where a counter without a guard would underflow into a 512-cycle period.

After a reset taken with the load input high, the bench checks that the divider runs from the bus value at reset and not from a stale one.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
    localparam int unsigned M_BITS       = 9;
    localparam int unsigned M_LOCK_LOW   = 190;
    localparam int unsigned M_LOCK_HIGH  = 510;
    localparam int unsigned REF_DIV_LOG2 = 4;
endpackage

// File: rtl/fbdiv_mload.sv
// Divide-value holding stage: transparent while load_n is low, frozen while high.
module fbdiv_mload #(
    parameter int unsigned M_W = fbdiv_pkg::M_BITS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_n,
    input  logic [M_W-1:0] m_in,
    output logic [M_W-1:0] m_eff,
    output logic [M_W-1:0] m_hold
);
    typedef struct packed {
        logic [M_W-1:0] hold;
    } ld_state_t;

    ld_state_t st_d, st_q;
    logic      pass;

    assign pass = rst || !load_n;

    always_comb begin
        st_d = st_q;
        if (pass) begin
            st_d.hold = m_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign m_hold = st_q.hold;
    assign m_eff  = pass ? m_in : st_q.hold;
endmodule

// File: rtl/fbdiv_count.sv
// Down counter that reloads from the effective divide value at terminal count.
module fbdiv_count #(
    parameter int unsigned M_W = fbdiv_pkg::M_BITS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] m_eff,
    output logic           pulse
);
    typedef struct packed {
        logic [M_W-1:0] cnt;
        logic           pulse;
    } cnt_state_t;

    localparam logic [M_W-1:0] ONE = M_W'(1);

    cnt_state_t st_d, st_q;

    function automatic logic [M_W-1:0] reload_of(input logic [M_W-1:0] m);
        return (m <= ONE) ? '0 : m - ONE;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (rst) begin
            st_d.cnt = reload_of(m_eff);
        end else if (st_q.cnt == '0) begin
            st_d.cnt   = reload_of(m_eff);
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pulse = st_q.pulse;
endmodule

// File: rtl/fbdiv_prescale.sv
// Fixed power-of-two prescaler on the crystal clock; output is the counter MSB.
module fbdiv_prescale #(
    parameter int unsigned DIV_LOG2 = fbdiv_pkg::REF_DIV_LOG2
) (
    input  logic xtal_clk,
    input  logic rst,
    output logic ref_div
);
    typedef struct packed {
        logic [DIV_LOG2-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_LOG2'(1);
        end
    end

    always_ff @(posedge xtal_clk) begin
        st_q <= st_d;
    end

    assign ref_div = st_q.cnt[DIV_LOG2-1];
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top #(
    parameter int unsigned M_W          = fbdiv_pkg::M_BITS,
    parameter int unsigned M_LOW        = fbdiv_pkg::M_LOCK_LOW,
    parameter int unsigned M_HIGH       = fbdiv_pkg::M_LOCK_HIGH,
    parameter int unsigned REF_DIV_LOG2 = fbdiv_pkg::REF_DIV_LOG2
) (
    input  logic           clk,
    input  logic           xtal_clk,
    input  logic           rst,
    input  logic           load_n,
    input  logic [M_W-1:0] m_in,
    output logic           fb_pulse,
    output logic           range_err,
    output logic           out_div2,
    output logic           ref_div
);
    localparam logic [M_W-1:0] LIM_LO = M_W'(M_LOW);
    localparam logic [M_W-1:0] LIM_HI = M_W'(M_HIGH);

    typedef struct packed {
        logic range_err;
        logic div2;
    } top_state_t;

    logic [M_W-1:0] m_eff;
    logic [M_W-1:0] m_hold;
    top_state_t     st_d, st_q;

    fbdiv_mload #(.M_W(M_W)) u_mload (
        .clk    (clk),
        .rst    (rst),
        .load_n (load_n),
        .m_in   (m_in),
        .m_eff  (m_eff),
        .m_hold (m_hold)
    );

    fbdiv_count #(.M_W(M_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .m_eff (m_eff),
        .pulse (fb_pulse)
    );

    fbdiv_prescale #(.DIV_LOG2(REF_DIV_LOG2)) u_pre (
        .xtal_clk (xtal_clk),
        .rst      (rst),
        .ref_div  (ref_div)
    );

    always_comb begin
        st_d           = st_q;
        st_d.range_err = (m_eff < LIM_LO) || (m_eff > LIM_HI);
        st_d.div2      = rst ? 1'b0 : !st_q.div2;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign range_err = st_q.range_err;
    assign out_div2  = st_q.div2;
endmodule

// File: rtl/fbdiv_top_chk.sv
module fbdiv_top_chk #(
    parameter int unsigned M_W    = fbdiv_pkg::M_BITS,
    parameter int unsigned M_LOW  = fbdiv_pkg::M_LOCK_LOW,
    parameter int unsigned M_HIGH = fbdiv_pkg::M_LOCK_HIGH
) (
    input logic           clk,
    input logic           xtal_clk,
    input logic           rst,
    input logic           load_n,
    input logic [M_W-1:0] m_in,
    input logic [M_W-1:0] m_eff,
    input logic [M_W-1:0] m_hold,
    input logic           fb_pulse,
    input logic           range_err,
    input logic           out_div2,
    input logic           ref_div
);
    localparam logic [M_W-1:0] LIM_LO = M_W'(M_LOW);
    localparam logic [M_W-1:0] LIM_HI = M_W'(M_HIGH);
    localparam logic [M_W-1:0] ONE    = M_W'(1);

    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) && rst |-> !fb_pulse && !out_div2); // R1
    AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (rst) !$past(load_n) |-> m_hold == $past(m_in)); // R3
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst) ($past(load_n) && !$past(rst)) |-> $stable(m_hold)); // R4
    AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (rst) (fb_pulse && ($past(m_eff) > ONE)) |=> !fb_pulse); // R5
    AST_PULSE_SOLID: assert property (@(posedge clk) disable iff (rst) (fb_pulse && ($past(m_eff) <= ONE)) |=> fb_pulse); // R7
    AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> range_err == (($past(m_eff) < LIM_LO) || ($past(m_eff) > LIM_HI))); // R8
    AST_DIV2_FALL: assert property (@(posedge clk) disable iff (rst) out_div2 |=> !out_div2); // R9
    AST_DIV2_RISE: assert property (@(posedge clk) disable iff (rst) !out_div2 |=> out_div2); // R9
    AST_REF_HOLD_HIGH: assert property (@(posedge xtal_clk) disable iff (rst) $rose(ref_div) |=> ref_div); // R10
    AST_REF_HOLD_LOW: assert property (@(posedge xtal_clk) disable iff (rst) $fell(ref_div) |=> !ref_div); // R10
endmodule

bind fbdiv_top fbdiv_top_chk #(.M_W(M_W), .M_LOW(M_LOW), .M_HIGH(M_HIGH)) u_chk (
    .clk       (clk),
    .xtal_clk  (xtal_clk),
    .rst       (rst),
    .load_n    (load_n),
    .m_in      (m_in),
    .m_eff     (m_eff),
    .m_hold    (m_hold),
    .fb_pulse  (fb_pulse),
    .range_err (range_err),
    .out_div2  (out_div2),
    .ref_div   (ref_div)
);

// File: tb/fbdiv_top_tb.sv
module fbdiv_top_tb;
    logic       clk = 1'b0;
    logic       xtal_clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic [8:0] m_in = 9'd100;
    logic       fb_pulse, range_err, out_div2, ref_div;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;
    always #40 xtal_clk = ~xtal_clk;

    fbdiv_top u_dut (
        .clk       (clk),
        .xtal_clk  (xtal_clk),
        .rst       (rst),
        .load_n    (load_n),
        .m_in      (m_in),
        .fb_pulse  (fb_pulse),
        .range_err (range_err),
        .out_div2  (out_div2),
        .ref_div   (ref_div)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (fb_pulse) return;
        end
    endtask

    task automatic measure_period(output int p);
        wait_pulse();
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!fb_pulse && p < 2000);
    endtask

    task automatic t_reset();
        int p;
        repeat (12) @(negedge clk);
        check_eq("R1 fb_pulse in reset", int'(fb_pulse), 0);
        check_eq("R1 out_div2 in reset", int'(out_div2), 0);
        check_eq("R1 ref_div in reset", int'(ref_div), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R11 range_err from reset load", int'(range_err), 1);
        m_in = 9'd250;
        measure_period(p);
        check_eq("R11 period from value loaded in reset", p, 100);
        check_eq("R4 range_err ignores bus after reset", int'(range_err), 1);
    endtask

    task automatic t_div2();
        logic prev;
        @(negedge clk);
        prev = out_div2;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check_eq("R9 out_div2 toggles", int'(out_div2), int'(!prev));
            prev = out_div2;
        end
    endtask

    task automatic t_transparent();
        int p, w;
        load_n = 1'b0;
        m_in = 9'd200;
        @(negedge clk);
        check_eq("R2 range_err follows bus", int'(range_err), 0);
        measure_period(p);
        check_eq("R2 period follows bus", p, 200);
        w = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            w += int'(fb_pulse);
        end
        check_eq("R5 pulse one cycle wide", w, 0);
    endtask

    task automatic t_range();
        int vals [4] = '{189, 190, 510, 511};
        int exps [4] = '{1, 0, 0, 1};
        load_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            m_in = 9'(vals[i]);
            @(negedge clk);
            @(negedge clk);
            check_eq($sformatf("R8 range_err at %0d", vals[i]), int'(range_err), exps[i]);
        end
    endtask

    task automatic t_capture();
        int p;
        load_n = 1'b0;
        m_in = 9'd250;
        @(negedge clk);
        @(negedge clk);
        load_n = 1'b1;
        @(negedge clk);
        m_in = 9'd300;
        @(negedge clk);
        m_in = 9'd100;
        repeat (3) @(negedge clk);
        check_eq("R4 range_err ignores bus while held", int'(range_err), 0);
        measure_period(p);
        check_eq("R4 period ignores bus while held", p, 250);
        measure_period(p);
        check_eq("R3 captured value persists", p, 250);
        load_n = 1'b0;
        @(negedge clk);
        check_eq("R2 reopening latch shows bus", int'(range_err), 1);
    endtask

    task automatic t_midcount();
        int p;
        load_n = 1'b0;
        m_in = 9'd200;
        wait_pulse();
        wait_pulse();
        p = 0;
        do begin
            @(negedge clk);
            p++;
            if (p == 50) m_in = 9'd300;
        end while (!fb_pulse && p < 2000);
        check_eq("R6 period in progress unchanged", p, 200);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!fb_pulse && p < 2000);
        check_eq("R6 new value after reload", p, 300);
    endtask

    task automatic t_small();
        int ones;
        load_n = 1'b0;
        m_in = 9'd1;
        wait_pulse();
        @(negedge clk);
        ones = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            ones += int'(fb_pulse);
        end
        check_eq("R7 M=1 pulse every cycle", ones, 5);
        m_in = 9'd0;
        @(negedge clk);
        ones = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            ones += int'(fb_pulse);
        end
        check_eq("R7 M=0 pulse every cycle", ones, 5);
    endtask

    task automatic t_ref();
        int h, l;
        for (int i = 0; i < 40 && ref_div; i++) @(negedge xtal_clk);
        for (int i = 0; i < 40 && !ref_div; i++) @(negedge xtal_clk);
        h = 1;
        forever begin
            @(negedge xtal_clk);
            if (ref_div && h < 40) h++;
            else break;
        end
        l = 1;
        forever begin
            @(negedge xtal_clk);
            if (!ref_div && l < 40) l++;
            else break;
        end
        check_eq("R10 ref_div high span", h, 8);
        check_eq("R10 ref_div low span", l, 8);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_div2();
        t_transparent();
        t_range();
        t_capture();
        t_midcount();
        t_small();
        t_ref();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule